// File: doc/BRIEF.md
# Egress Port Arbiter with Round-Robin, Weighted and Time-Slotted Modes

This block sits at one egress port of a packet switch. For a single virtual channel, it picks which ingress source sends the next packet. The sources are the external ingress ports. On an upstream port there is also one internal source, which carries locally generated packets such as configuration completions. A grant stays in place until the packet-done strobe arrives. Only after that does the arbiter make its next decision.

There are three arbitration modes. The first is plain rotating round-robin. The second is a weighted walk over a 128-phase table, where each phase names a source. The third is time-slotted: the same table is stepped by a free-running slot clock, and the source named by the current phase may be served at most once in that slot. The table is written through a simple index/port write port, and writes are accepted only while no grant is active. The mode input is sampled only when a decision is made, so a new mode takes effect at the next packet boundary.

Top module: `egress_port_arbiter`

## Requirements
- R1: After reset, `gnt` is all zero and `gnt_valid` is 0. Every table phase k holds source k mod N, where N = NUM_EXT + 1 on an upstream port.
- R2: `gnt` is one-hot with its set bit at `gnt_idx` whenever `gnt_valid` is 1, and it is all zero otherwise.
- R3: When the arbiter is idle at a clock edge and the selected mode finds a requester, the grant appears after that edge. The grant holds with an unchanged index until an edge at which `pkt_done` is 1, and it drops after that edge. `pkt_done` while idle has no effect.
- R4: With `mode_sel` = 0 or 3 (round-robin), the search starts at the source after the last source granted in round-robin mode and wraps upward. After reset the last source is taken as N-1.
- R5: With `mode_sel` = 1 (weighted), the phase pointer starts at 0 after reset. The arbiter grants the source of the first phase, at or after the pointer and wrapping, whose source is requesting. The pointer then moves to that phase plus one.
- R6: With `mode_sel` = 2 (time-slotted), the slot pointer advances by one phase every SLOT_CYCLES clocks from reset, whatever the mode and the requests. A grant is made only to the source of the current phase when it is requesting, and at most once per slot. A phase whose source is idle issues no grant.
- R7: A table write (`tbl_we`, `tbl_idx`, `tbl_port`) takes effect only at an edge where no grant is active. It is ignored otherwise.
- R8: `mode_sel` is used only at the decision edge. Changing it while a grant is active has no effect on that grant.
- R9: The internal source uses index N-1 (bit N-1 of `gnt`) and competes under the same rules as external sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_req | input | NUM_EXT | Request lines from the external ingress ports |
| local_req | input | 1 | Request from the internal source (upstream port only) |
| mode_sel | input | 2 | 0/3 round-robin, 1 weighted table, 2 time-slotted table |
| pkt_done | input | 1 | The granted packet has finished |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | $clog2(PHASES) | Phase to write |
| tbl_port | input | IDW | Source number to store |
| gnt | output | N | One-hot grant |
| gnt_valid | output | 1 | A grant is active |
| gnt_idx | output | IDW | Index of the granted source |

## Verification
The hardest cases to reach from the ports are in time-slotted mode. There, the outcome depends on where the free-running slot counter happens to be when the arbiter goes idle. One case is a phase whose source is idle for its whole slot. Another is a grant that finishes within its slot while the same source asks again. The bench keeps its own slot count from the reset release and drives random request patterns and random packet lengths for thousands of cycles. This walks the 512-cycle table rotation several times, so the arbiter lands on every slot offset with both idle and busy phase owners. The bench also issues table writes while grants are active and toggles the mode in mid-grant. Its cycle model then shows whether any of these leaked into later decisions.

// File: rtl/egress_arb_pkg.sv
package egress_arb_pkg;
  typedef enum logic [1:0] {
    ARB_RR   = 2'd0,
    ARB_WRR  = 2'd1,
    ARB_TIME = 2'd2,
    ARB_RR2  = 2'd3
  } arb_mode_e;
endpackage

// File: rtl/arb_phase_table.sv
module arb_phase_table #(
  parameter int N      = 4,
  parameter int PHASES = 128,
  parameter int IDW    = 2,
  parameter int PW     = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [PW-1:0]           wr_idx,
  input  logic [IDW-1:0]          wr_port,
  output logic [PHASES*IDW-1:0]   tbl_flat
);
  logic [IDW-1:0] mem [PHASES];

  // default owner of a phase: round-robin over the sources
  function automatic logic [IDW-1:0] default_owner(input int ph);
    return IDW'(ph % N);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PHASES; i++) mem[i] <= default_owner(i);
    end else if (wr_en) begin
      mem[wr_idx] <= wr_port;
    end
  end

  for (genvar g = 0; g < PHASES; g++) begin : g_flat
    assign tbl_flat[g*IDW +: IDW] = mem[g];
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic [N-1:0]   req,
  input  logic [IDW-1:0] last,
  output logic           hit,
  output logic [IDW-1:0] port
);
  // rotating search beginning one past the last winner
  function automatic logic [IDW:0] rr_search(input logic [N-1:0] r,
                                              input logic [IDW-1:0] l);
    logic [IDW:0] res;
    int p;
    res = '0;
    for (int off = N; off >= 1; off--) begin
      p = (int'(l) + off) % N;
      if (r[p]) res = {1'b1, IDW'(p)};
    end
    return res;
  endfunction

  logic [IDW:0] found;
  assign found = rr_search(req, last);
  assign hit   = found[IDW];
  assign port  = found[IDW-1:0];
endmodule

// File: rtl/arb_phase_search.sv
module arb_phase_search #(
  parameter int PHASES = 128,
  parameter int PW     = 7,
  parameter int IDW    = 2,
  parameter int NP     = 4
) (
  input  logic [PHASES*IDW-1:0] tbl_flat,
  input  logic [NP-1:0]         req,
  input  logic [PW-1:0]         start,
  output logic                  hit,
  output logic [PW-1:0]         phase
);
  // first phase at or after start (wrapping) whose owner requests
  function automatic logic [PW:0] walk(input logic [PHASES*IDW-1:0] t,
                                       input logic [NP-1:0] r,
                                       input logic [PW-1:0] s);
    logic [PW:0]    res;
    logic [PW-1:0]  ph;
    logic [IDW-1:0] own;
    res = '0;
    for (int off = PHASES - 1; off >= 0; off--) begin
      ph  = PW'(int'(s) + off);
      own = t[int'(ph)*IDW +: IDW];
      if (r[own]) res = {1'b1, ph};
    end
    return res;
  endfunction

  logic [PW:0] found;
  assign found = walk(tbl_flat, req, start);
  assign hit   = found[PW];
  assign phase = found[PW-1:0];
endmodule

// File: rtl/arb_time_slot.sv
module arb_time_slot #(
  parameter int SLOT_CYCLES = 4,
  parameter int PW          = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  output logic [PW-1:0] tptr,
  output logic          slot_open
);
  localparam int SW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;

  logic [SW-1:0] scnt;
  logic          used;
  logic          slot_wrap;

  assign slot_wrap = (int'(scnt) == SLOT_CYCLES - 1);
  assign slot_open = !used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt <= '0;
      tptr <= '0;
      used <= 1'b0;
    end else if (slot_wrap) begin
      scnt <= '0;
      tptr <= tptr + 1'b1;
      used <= 1'b0;
    end else begin
      scnt <= scnt + 1'b1;
      if (take) used <= 1'b1;
    end
  end

  AST_ONE_GRANT_PER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_open |-> !take); // R6
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    slot_wrap |=> tptr == PW'($past(tptr) + 1'b1)); // R6
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_wrap |=> $stable(tptr)); // R6
endmodule

// File: rtl/egress_port_arbiter.sv
module egress_port_arbiter
  import egress_arb_pkg::*;
#(
  parameter int NUM_EXT     = 3,
  parameter bit IS_UPSTREAM = 1'b1,
  parameter int PHASES      = 128,
  parameter int SLOT_CYCLES = 4,
  localparam int N   = NUM_EXT + (IS_UPSTREAM ? 1 : 0),
  localparam int IDW = (N > 1) ? $clog2(N) : 1,
  localparam int PW  = $clog2(PHASES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_req,
  input  logic               local_req,
  input  logic [1:0]         mode_sel,
  input  logic               pkt_done,
  input  logic               tbl_we,
  input  logic [PW-1:0]      tbl_idx,
  input  logic [IDW-1:0]     tbl_port,
  output logic [N-1:0]       gnt,
  output logic               gnt_valid,
  output logic [IDW-1:0]     gnt_idx
);
  localparam int NP = 1 << IDW;

  // request vector, internal source on the top index
  logic [N-1:0]  req_all;
  logic [NP-1:0] req_pad;

  if (IS_UPSTREAM) begin : g_up
    assign req_all = {local_req, ext_req};
  end else begin : g_down
    assign req_all = ext_req;
    logic unused_local;
    assign unused_local = local_req;
  end

  always_comb begin
    req_pad = '0;
    req_pad[N-1:0] = req_all;
  end

  // state
  logic            busy;
  logic [IDW-1:0]  gnt_q;
  logic [IDW-1:0]  rr_last;
  logic [PW-1:0]   wptr;
  arb_mode_e       mode_now;

  assign mode_now = arb_mode_e'(mode_sel);

  // phase table
  logic [PHASES*IDW-1:0] tbl_flat;
  logic                  tbl_wr_ok;

  assign tbl_wr_ok = tbl_we && !busy;

  arb_phase_table #(.N(N), .PHASES(PHASES), .IDW(IDW), .PW(PW)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_wr_ok),
    .wr_idx   (tbl_idx),
    .wr_port  (tbl_port),
    .tbl_flat (tbl_flat)
  );

  function automatic logic [IDW-1:0] owner_of(input logic [PHASES*IDW-1:0] t,
                                              input logic [PW-1:0] ph);
    return t[int'(ph)*IDW +: IDW];
  endfunction

  // round-robin candidate
  logic           rr_hit;
  logic [IDW-1:0] rr_port;

  arb_rr_pick #(.N(N), .IDW(IDW)) u_rr (
    .req  (req_all),
    .last (rr_last),
    .hit  (rr_hit),
    .port (rr_port)
  );

  // weighted candidate
  logic           wrr_hit;
  logic [PW-1:0]  wrr_phase;
  logic [IDW-1:0] wrr_port;

  arb_phase_search #(.PHASES(PHASES), .PW(PW), .IDW(IDW), .NP(NP)) u_wrr (
    .tbl_flat (tbl_flat),
    .req      (req_pad),
    .start    (wptr),
    .hit      (wrr_hit),
    .phase    (wrr_phase)
  );
  assign wrr_port = owner_of(tbl_flat, wrr_phase);

  // time-slotted candidate
  logic           time_take;
  logic [PW-1:0]  tptr;
  logic           slot_open;
  logic [IDW-1:0] tm_port;
  logic           tm_hit;

  arb_time_slot #(.SLOT_CYCLES(SLOT_CYCLES), .PW(PW)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (time_take),
    .tptr      (tptr),
    .slot_open (slot_open)
  );
  assign tm_port = owner_of(tbl_flat, tptr);
  assign tm_hit  = slot_open && req_pad[tm_port];

  // decision
  logic           sel_hit;
  logic [IDW-1:0] sel_idx;
  logic           dec_fire;
  logic [IDW-1:0] dec_idx;

  always_comb begin
    case (mode_now)
      ARB_WRR:  begin sel_hit = wrr_hit; sel_idx = wrr_port; end
      ARB_TIME: begin sel_hit = tm_hit;  sel_idx = tm_port;  end
      default:  begin sel_hit = rr_hit;  sel_idx = rr_port;  end
    endcase
  end

  assign dec_fire  = !busy && sel_hit;
  assign dec_idx   = sel_idx;
  assign time_take = dec_fire && (mode_now == ARB_TIME);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      gnt_q   <= '0;
      rr_last <= IDW'(N - 1);
      wptr    <= '0;
    end else if (!busy) begin
      if (dec_fire) begin
        busy  <= 1'b1;
        gnt_q <= dec_idx;
        if (mode_now == ARB_RR || mode_now == ARB_RR2) rr_last <= dec_idx;
        if (mode_now == ARB_WRR) wptr <= wrr_phase + 1'b1;
      end
    end else if (pkt_done) begin
      busy <= 1'b0;
    end
  end

  // outputs
  logic [NP-1:0] gnt_pad;
  assign gnt_pad   = NP'(1) << gnt_q;
  assign gnt       = busy ? gnt_pad[N-1:0] : '0;
  assign gnt_valid = busy;
  assign gnt_idx   = gnt_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> ($countones(gnt) == 1) && gnt[gnt_idx]); // R2
  AST_GNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid |-> (gnt == '0)); // R2
  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && !pkt_done |=> gnt_valid && $stable(gnt_idx)); // R3
  AST_GNT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && pkt_done |=> !gnt_valid); // R3
  AST_DEC_TO_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire |-> req_pad[dec_idx]); // R4
  AST_DEC_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire |=> gnt_valid && gnt_idx == $past(dec_idx)); // R3
  AST_TBL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |=> $stable(tbl_flat)); // R7
  AST_IDLE_PHASE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == ARB_TIME) && !req_pad[tm_port] |-> !dec_fire); // R6
endmodule

// File: tb/sim_egress_port_arbiter.sv
module sim_egress_port_arbiter;
  localparam int NUM_EXT = 3;
  localparam int N       = 4;
  localparam int IDW     = 2;
  localparam int PHASES  = 128;
  localparam int PW      = 7;
  localparam int SLOT    = 4;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_EXT-1:0] ext_req = '0;
  logic               local_req = 1'b0;
  logic [1:0]         mode_sel = 2'd0;
  logic               pkt_done = 1'b0;
  logic               tbl_we = 1'b0;
  logic [PW-1:0]      tbl_idx = '0;
  logic [IDW-1:0]     tbl_port = '0;
  logic [N-1:0]       gnt;
  logic               gnt_valid;
  logic [IDW-1:0]     gnt_idx;

  always #10 clk = ~clk;

  egress_port_arbiter #(.NUM_EXT(NUM_EXT), .IS_UPSTREAM(1'b1),
                        .PHASES(PHASES), .SLOT_CYCLES(SLOT)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .local_req(local_req),
    .mode_sel(mode_sel), .pkt_done(pkt_done), .tbl_we(tbl_we),
    .tbl_idx(tbl_idx), .tbl_port(tbl_port), .gnt(gnt),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx));

  int    n_chk = 0;
  int    n_bad = 0;
  bit    run_chk = 1'b0;
  string ph = "setup";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s (%s) act=%0d exp=%0d", req, ph, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  // ---------------- reference model, stepped on each rising edge ----------
  bit    m_busy;
  int    m_idx, m_last, m_wptr, m_tptr, m_scnt;
  bit    m_used;
  int    m_tbl [PHASES];
  string m_tag = "R4";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_idx = 0; m_last = N - 1; m_wptr = 0;
      m_tptr = 0; m_scnt = 0; m_used = 0;
      for (int i = 0; i < PHASES; i++) m_tbl[i] = i % N;   // R1
    end else begin
      bit [N-1:0] rq;
      bit fire, found;
      int pick, nwp, p;
      rq = {local_req, ext_req};
      fire = 0; pick = 0; nwp = m_wptr; found = 0;
      if (!m_busy) begin
        if (mode_sel == 2'd1) begin            // R5 weighted walk
          for (int off = 0; off < PHASES; off++) begin
            p = (m_wptr + off) % PHASES;
            if (!found && rq[m_tbl[p]]) begin
              found = 1; pick = m_tbl[p]; nwp = (p + 1) % PHASES;
            end
          end
          fire = found;
        end else if (mode_sel == 2'd2) begin   // R6 slot owner only
          if (!m_used && rq[m_tbl[m_tptr]]) begin
            fire = 1; pick = m_tbl[m_tptr];
          end
        end else begin                          // R4 rotation
          for (int off = 1; off <= N; off++) begin
            p = (m_last + off) % N;
            if (!found && rq[p]) begin found = 1; pick = p; end
          end
          fire = found;
        end
        if (tbl_we) m_tbl[tbl_idx] = tbl_port;  // R7 only when idle
        if (fire) begin
          m_busy = 1; m_idx = pick;
          if (mode_sel == 2'd1) begin m_wptr = nwp; m_tag = "R5"; end
          else if (mode_sel == 2'd2) m_tag = "R6";
          else begin m_last = pick; m_tag = "R4"; end
          if (pick == N - 1) m_tag = {m_tag, "/R9"};
        end
      end else if (pkt_done) begin
        m_busy = 0;
      end
      if (m_scnt == SLOT - 1) begin
        m_scnt = 0; m_tptr = (m_tptr + 1) % PHASES; m_used = 0;
      end else begin
        m_scnt++;
        if (fire && mode_sel == 2'd2) m_used = 1;
      end
    end
  end

  // ---------------- continuous comparison, away from the edge ------------
  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      chk(gnt_valid == m_busy, "R3", int'(gnt_valid), int'(m_busy));
      if (m_busy) chk(int'(gnt_idx) == m_idx, m_tag, int'(gnt_idx), m_idx);
      chk(int'(gnt) == (m_busy ? (1 << m_idx) : 0), "R2", int'(gnt),
          m_busy ? (1 << m_idx) : 0);
    end
  end

  // ---------------- watchdog ---------------------------------------------
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (%s) act=%0d exp=%0d", ph, wd, 150000);
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ---------------------------------------------
  task automatic one_grant(input logic [3:0] rq, input int exp, input string tag);
    @(negedge clk);
    {local_req, ext_req} = rq; pkt_done = 0;
    @(negedge clk);
    chk(gnt_valid && int'(gnt_idx) == exp, tag, int'(gnt_idx), exp);
    pkt_done = 1;
    @(negedge clk);
    pkt_done = 0; {local_req, ext_req} = '0;
  endtask

  task automatic run(input int cyc, input int mode, input bit jitter, input int we_pct);
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if ($urandom % 2) {local_req, ext_req} = 4'(k / 3);
      else {local_req, ext_req} = 4'($urandom);
      pkt_done = ($urandom % 3) == 0;
      mode_sel = jitter ? 2'($urandom) : 2'(mode);
      tbl_we   = ($urandom % 100) < we_pct;
      tbl_idx  = PW'($urandom);
      tbl_port = IDW'($urandom);
    end
    @(negedge clk);
    {local_req, ext_req} = '0; tbl_we = 0;
    pkt_done = 1;
    @(negedge clk);
    pkt_done = 0;
  endtask

  initial begin
    ph = "R1 reset";
    repeat (3) @(negedge clk);
    chk(gnt == '0, "R1", int'(gnt), 0);
    chk(gnt_valid == 1'b0, "R1", int'(gnt_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_chk = 1'b1;
    chk(gnt_valid == 1'b0 && gnt == '0, "R1", int'(gnt), 0);

    ph = "R4 rotation";
    mode_sel = 2'd0;
    one_grant(4'b1111, 0, "R4");
    one_grant(4'b1111, 1, "R4");
    one_grant(4'b1111, 2, "R4");
    one_grant(4'b1111, 3, "R9");
    one_grant(4'b1111, 0, "R4");
    one_grant(4'b1000, 3, "R9");
    one_grant(4'b0101, 0, "R4");
    mode_sel = 2'd3;
    one_grant(4'b0101, 2, "R4");

    ph = "R3 idle done ignored";
    @(negedge clk); pkt_done = 1;
    @(negedge clk); pkt_done = 0;
    chk(gnt_valid == 1'b0, "R3", int'(gnt_valid), 0);

    ph = "R1/R5 default table";
    mode_sel = 2'd1;
    one_grant(4'b0100, 2, "R1");
    one_grant(4'b1111, 3, "R5");
    one_grant(4'b0010, 1, "R5");

    ph = "R4 random";
    run(1500, 0, 1'b0, 10);

    ph = "R7 idle writes";
    mode_sel = 2'd0;
    for (int i = 0; i < PHASES; i++) begin
      @(negedge clk);
      tbl_we = 1; tbl_idx = PW'(i); tbl_port = IDW'((i * 3 + i / 5) % N);
    end
    @(negedge clk); tbl_we = 0;

    ph = "R7 writes while granted";
    {local_req, ext_req} = 4'b1111;
    @(negedge clk);
    {local_req, ext_req} = '0;
    for (int i = 0; i < PHASES; i++) begin
      @(negedge clk);
      tbl_we = 1; tbl_idx = PW'(i); tbl_port = IDW'(1);
    end
    @(negedge clk); tbl_we = 0; pkt_done = 1;
    @(negedge clk); pkt_done = 0;

    ph = "R5 random";
    run(2000, 1, 1'b0, 0);
    ph = "R6 random";
    run(3000, 2, 1'b0, 0);
    ph = "R8 mode changes mid-grant";
    run(3000, 0, 1'b1, 5);
    ph = "R6 after table churn";
    run(2000, 2, 1'b0, 0);

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule